// File: doc/BRIEF.md
# Dual-Lane Deskew and Pixel Merger

This block takes a pixel stream that was split into two half-rate lanes and puts it back together. Lane A carries the odd pixels and lane B carries the even pixels. The two lanes can arrive with different latency. Each lane writes into its own small FIFO. The block releases nothing until both FIFOs hold at least one word. From then on it reads both FIFOs in lockstep, one pair every two clock cycles. Each released pair passes through a two-stage register and is interleaved into a full-rate stream: the odd pixel first, then the even pixel.

Everything runs on one clock, which is the full-rate pixel clock. Each lane delivers at most one word every two cycles, so one lane-clock period is two cycles. Control bits (sync and blanking) travel on lane A only. They are attached to both output pixels of their pair. If a FIFO runs dry at a pair slot, the output valid drops and the block goes back to waiting for both lanes. A write into a full FIFO is dropped and sets a sticky error flag.

Top module: `dual_lane_deskew`

## Requirements
- R1: After reset, `pix_vld` and `ovf_err` are 0.
- R2: Each lane FIFO holds `FIFO_DEPTH` words (default 4). No pixel is output while either FIFO is empty, no matter how many words the other lane has queued.
- R3: The n-th word of lane A and the n-th word of lane B form a pair. The pair's lane-A pixel is output first and its lane-B pixel on the very next cycle.
- R4: Skew between the lanes of up to one lane period (two clock cycles), in either direction, is absorbed and the output order is unchanged. This includes a half-period (one cycle) offset.
- R5: When both lanes stream continuously, the merged output shows exactly 2N consecutive valid cycles for N pairs, with no gap (full rate).
- R6: The `a_ctl` value written with lane A's n-th word appears on `pix_ctl` for both output pixels of pair n.
- R7: If either FIFO is empty at a pair slot, `pix_vld` drops and the block waits again for both lanes. Pairs released later keep their order and pairing.
- R8: A write into a full FIFO is discarded. It sets `ovf_err`, which stays 1 until reset. No write during normal streaming sets it.
- R9: The two FIFOs are popped together, never on two consecutive cycles, and never while empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Full-rate pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| a_vld | input | 1 | Lane A (odd pixels) word strobe |
| a_pix | input | PIX_W | Lane A pixel |
| a_ctl | input | CTL_W | Control bits carried with lane A |
| b_vld | input | 1 | Lane B (even pixels) word strobe |
| b_pix | input | PIX_W | Lane B pixel |
| pix_vld | output | 1 | Merged pixel valid |
| pix_dat | output | PIX_W | Merged full-rate pixel |
| pix_ctl | output | CTL_W | Control bits for the current pixel |
| ovf_err | output | 1 | Sticky FIFO overflow flag |

## Verification
Lane patterns cover aligned arrival, lane B lagging by a full lane period, lane A lagging by a full lane period, and one-cycle offsets in both directions. These show that the release waits for the later lane whichever lane is late. They also show that skew never swaps or shifts the pairing. Streams with a mid-run pause on lane B separate a correct re-arm (a gap in the output, order kept) from a block that keeps reading a stale or empty FIFO. A lane-A-only stream shows that one lane alone releases nothing. Pushing it past the FIFO depth shows that the extra word is dropped and that the flag stays set.

// File: rtl/dsk_pkg.sv
package dsk_pkg;
  typedef enum logic {
    ARM_WAIT = 1'b0,
    ARM_RUN  = 1'b1
  } arm_t;
endpackage

// File: rtl/dsk_lane_fifo.sv
module dsk_lane_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_dat,
  input  logic         rd_en,
  output logic [W-1:0] rd_dat,
  output logic         nempty,
  output logic         ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          full, wr_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (cnt == CW'(DEPTH));
  assign wr_ok  = wr_en && !full;
  assign ovf    = wr_en && full;
  assign nempty = (cnt != '0);
  assign rd_dat = mem[rp];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wr_dat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_ok) wp <= ptr_inc(wp);
      if (rd_en) rp <= ptr_inc(rp);
      cnt <= cnt + CW'(wr_ok) - CW'(rd_en);
    end
  end

  AST_NO_RD_EMPTY: assert property (@(posedge clk) disable iff (rst) rd_en |-> cnt != '0); // R9
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst) cnt <= CW'(DEPTH)); // R2
endmodule

// File: rtl/dsk_align.sv
module dsk_align
  import dsk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ne_a,
  input  logic ne_b,
  output logic pop
);
  arm_t st;
  logic ph;   // 1: second cycle of a pair slot, no pop allowed
  logic both;

  assign both = ne_a && ne_b;

  always_comb begin
    pop = 1'b0;
    if (st == ARM_WAIT) pop = both;
    else                pop = !ph && both;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ARM_WAIT;
      ph <= 1'b0;
    end else begin
      case (st)
        ARM_WAIT: begin
          if (pop) begin
            st <= ARM_RUN;
            ph <= 1'b1;
          end
        end
        default: begin
          if (ph)       ph <= 1'b0;
          else if (pop) ph <= 1'b1;
          else          st <= ARM_WAIT;   // underflow: re-arm
        end
      endcase
    end
  end

  AST_POP_SPACED: assert property (@(posedge clk) disable iff (rst) pop |=> !pop); // R9
endmodule

// File: rtl/dsk_merge.sv
module dsk_merge #(
  parameter int PIX_W = 16,
  parameter int CTL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pop,
  input  logic [PIX_W-1:0] odd_in,
  input  logic [PIX_W-1:0] even_in,
  input  logic [CTL_W-1:0] ctl_in,
  output logic             pix_vld,
  output logic [PIX_W-1:0] pix_dat,
  output logic [CTL_W-1:0] pix_ctl
);
  logic [PIX_W-1:0] s1_odd, s1_even, s2_odd, s2_even;
  logic [CTL_W-1:0] s1_ctl, s2_ctl;
  logic             s1_new, pend_odd, pend_even, out_even;

  // first stage: both lanes captured side by side
  always_ff @(posedge clk) begin
    if (pop) begin
      s1_odd  <= odd_in;
      s1_even <= even_in;
      s1_ctl  <= ctl_in;
    end
    if (s1_new) begin
      s2_odd  <= s1_odd;
      s2_even <= s1_even;
      s2_ctl  <= s1_ctl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_new    <= 1'b0;
      pend_odd  <= 1'b0;
      pend_even <= 1'b0;
      pix_vld   <= 1'b0;
      pix_dat   <= '0;
      pix_ctl   <= '0;
      out_even  <= 1'b0;
    end else begin
      s1_new    <= pop;
      pend_odd  <= s1_new;
      pend_even <= pend_odd;
      pix_vld   <= pend_odd || pend_even;
      if (pend_odd) begin
        pix_dat  <= s2_odd;
        pix_ctl  <= s2_ctl;
        out_even <= 1'b0;
      end else if (pend_even) begin
        pix_dat  <= s2_even;
        pix_ctl  <= s2_ctl;
        out_even <= 1'b1;
      end
    end
  end

  AST_EVEN_AFTER_ODD: assert property (@(posedge clk) disable iff (rst)
    (pix_vld && out_even) |-> $past(pix_vld && !out_even)); // R3
endmodule

// File: rtl/dual_lane_deskew.sv
module dual_lane_deskew #(
  parameter int PIX_W      = 16,
  parameter int CTL_W      = 3,
  parameter int FIFO_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_vld,
  input  logic [PIX_W-1:0] a_pix,
  input  logic [CTL_W-1:0] a_ctl,
  input  logic             b_vld,
  input  logic [PIX_W-1:0] b_pix,
  output logic             pix_vld,
  output logic [PIX_W-1:0] pix_dat,
  output logic [CTL_W-1:0] pix_ctl,
  output logic             ovf_err
);
  localparam int AW_W = PIX_W + CTL_W;

  logic [AW_W-1:0]  a_rd;
  logic [PIX_W-1:0] b_rd;
  logic             ne_a, ne_b, ovf_a, ovf_b, pop;

  dsk_lane_fifo #(.W(AW_W), .DEPTH(FIFO_DEPTH)) u_fifo_a (
    .clk(clk), .rst(rst), .wr_en(a_vld), .wr_dat({a_ctl, a_pix}),
    .rd_en(pop), .rd_dat(a_rd), .nempty(ne_a), .ovf(ovf_a));

  dsk_lane_fifo #(.W(PIX_W), .DEPTH(FIFO_DEPTH)) u_fifo_b (
    .clk(clk), .rst(rst), .wr_en(b_vld), .wr_dat(b_pix),
    .rd_en(pop), .rd_dat(b_rd), .nempty(ne_b), .ovf(ovf_b));

  dsk_align u_align (
    .clk(clk), .rst(rst), .ne_a(ne_a), .ne_b(ne_b), .pop(pop));

  dsk_merge #(.PIX_W(PIX_W), .CTL_W(CTL_W)) u_merge (
    .clk(clk), .rst(rst), .pop(pop),
    .odd_in(a_rd[PIX_W-1:0]), .even_in(b_rd), .ctl_in(a_rd[AW_W-1:PIX_W]),
    .pix_vld(pix_vld), .pix_dat(pix_dat), .pix_ctl(pix_ctl));

  always_ff @(posedge clk) begin
    if (rst) ovf_err <= 1'b0;
    else     ovf_err <= ovf_err | ovf_a | ovf_b;
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) ovf_err |=> ovf_err); // R8
endmodule

// File: tb/sim_dual_lane_deskew.sv
`timescale 1ns/1ps
module sim_dual_lane_deskew;
  localparam int PW = 16;
  localparam int CW = 3;
  localparam int NV = 7;
  // columns: a start, b start, pairs, b pause index, b pause slots
  localparam int VEC [0:NV-1][0:4] = '{
    '{0, 0, 8, 99, 0},   // R4 aligned
    '{0, 2, 8, 99, 0},   // R4 B one lane period late
    '{2, 0, 8, 99, 0},   // R4 A one lane period late
    '{0, 1, 8, 99, 0},   // R4 B half period late
    '{1, 0, 6, 99, 0},   // R4 A half period late
    '{0, 2, 8, 3, 1},    // R7 B pause mid-stream
    '{0, 0, 8, 5, 2}     // R7 longer pause
  };

  logic clk = 1'b0, rst = 1'b1;
  logic a_vld = 1'b0, b_vld = 1'b0;
  logic [PW-1:0] a_pix = '0, b_pix = '0;
  logic [CW-1:0] a_ctl = '0;
  logic pix_vld, ovf_err;
  logic [PW-1:0] pix_dat;
  logic [CW-1:0] pix_ctl;

  int checks = 0, fails = 0;
  int cyc = 0, ng = 0, first_c = 0, last_c = 0;
  logic [PW-1:0] got_p [64];
  logic [CW-1:0] got_c [64];

  always #2.5 clk = ~clk;

  dual_lane_deskew #(.PIX_W(PW), .CTL_W(CW), .FIFO_DEPTH(4)) u0 (
    .clk(clk), .rst(rst), .a_vld(a_vld), .a_pix(a_pix), .a_ctl(a_ctl),
    .b_vld(b_vld), .b_pix(b_pix), .pix_vld(pix_vld), .pix_dat(pix_dat),
    .pix_ctl(pix_ctl), .ovf_err(ovf_err));

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst) ng = 0;
    else if (pix_vld && ng < 64) begin
      if (ng == 0) first_c = cyc;
      last_c = cyc;
      got_p[ng] = pix_dat;
      got_c[ng] = pix_ctl;
      ng = ng + 1;
    end
  end

  function automatic logic [PW-1:0] pix_of(int s, int i, int lane);
    return PW'(16'h1000 + s * 256 + i * 2 + lane);
  endfunction
  function automatic logic [CW-1:0] ctl_of(int s, int i);
    return CW'(s * 3 + i + 1);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic do_reset();
    a_vld = 0; b_vld = 0; rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
  endtask

  task automatic push(int lane, int s, int i);
    @(posedge clk); #1;
    if (lane == 0) begin a_vld = 1; a_pix = pix_of(s, i, 0); a_ctl = ctl_of(s, i); end
    else begin b_vld = 1; b_pix = pix_of(s, i, 1); end
    @(posedge clk); #1;
    a_vld = 0; b_vld = 0;
  endtask

  task automatic check_pairs(int s, int n, string req);
    for (int k = 0; k < n; k++) begin
      chk(got_p[2*k] == pix_of(s, k, 0), {req, " odd pixel"}, int'(got_p[2*k]), int'(pix_of(s, k, 0)));
      chk(got_p[2*k+1] == pix_of(s, k, 1), {req, " even pixel"}, int'(got_p[2*k+1]), int'(pix_of(s, k, 1)));
      // R6 control from lane A on both pixels
      chk(got_c[2*k] == ctl_of(s, k) && got_c[2*k+1] == ctl_of(s, k), "R6 ctl",
          int'(got_c[2*k+1]), int'(ctl_of(s, k)));
    end
  endtask

  task automatic run_scn(int s);
    int sa, sb, n, pz, pl, ia, ib, tb;
    sa = VEC[s][0]; sb = VEC[s][1]; n = VEC[s][2]; pz = VEC[s][3]; pl = VEC[s][4];
    ia = 0; ib = 0;
    do_reset();
    for (int t = 0; t < 120; t++) begin
      @(posedge clk); #1;
      a_vld = 0; b_vld = 0;
      if (ia < n && t == sa + 2 * ia) begin
        a_vld = 1; a_pix = pix_of(s, ia, 0); a_ctl = ctl_of(s, ia); ia++;
      end
      tb = sb + 2 * ib + ((ib >= pz) ? 2 * pl : 0);
      if (ib < n && t == tb) begin
        b_vld = 1; b_pix = pix_of(s, ib, 1); ib++;
      end
    end
    repeat (2) @(negedge clk);
    chk(ng == 2 * n, "R3 pixel count", ng, 2 * n);
    if (ng == 2 * n) check_pairs(s, n, "R3/R4");
    if (pl == 0)
      chk(last_c - first_c + 1 == 2 * n, "R5 gapless span", last_c - first_c + 1, 2 * n);
    else
      chk(last_c - first_c + 1 > 2 * n, "R7 valid dropped", last_c - first_c + 1, 2 * n + 1);
    chk(ovf_err == 1'b0, "R8 no false overflow", int'(ovf_err), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk(pix_vld == 1'b0, "R1 pix_vld after reset", int'(pix_vld), 0);
    chk(ovf_err == 1'b0, "R1 ovf_err after reset", int'(ovf_err), 0);

    for (int s = 0; s < NV; s++) run_scn(s);

    // R2: one lane alone releases nothing
    do_reset();
    for (int i = 0; i < 3; i++) push(0, 9, i);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(ng == 0, "R2 single lane held", ng, 0);
    for (int i = 0; i < 3; i++) push(1, 9, i);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(ng == 6, "R2 released after both", ng, 6);
    if (ng == 6) check_pairs(9, 3, "R2");

    // R8: overflow on lane A
    do_reset();
    for (int i = 0; i < 4; i++) push(0, 10, i);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(ovf_err == 1'b0, "R8 full, no overflow yet", int'(ovf_err), 0);
    push(0, 10, 4);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(ovf_err == 1'b1, "R8 overflow flagged", int'(ovf_err), 1);
    chk(ng == 0, "R8 nothing released", ng, 0);
    for (int i = 0; i < 5; i++) push(1, 10, i);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(ng == 8, "R8 dropped word not paired", ng, 8);
    if (ng == 8) check_pairs(10, 4, "R8");
    chk(ovf_err == 1'b1, "R8 sticky", int'(ovf_err), 1);
    do_reset();
    @(negedge clk);
    chk(ovf_err == 1'b0, "R1 reset clears overflow", int'(ovf_err), 0);

    summary();
  end
endmodule